// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Port

This block is a serial-peripheral master that moves exactly one 8-bit frame per start command. Software programs it through a small byte-wide register port: a mode byte selects clock polarity, sampling phase, bit order, internal loopback and port enable; a divisor byte sets the serial clock rate; a transmit byte holds the outgoing data. Writing the start bit shifts the transmit byte out on `mosi` while `miso` is sampled. When the frame is complete, the received byte becomes readable and an interrupt is raised.

The block has no FIFO, so software services one interrupt per byte. It reads the receive register, which clears the interrupt, loads the next transmit byte and starts again. Busy status stays high for one extra cycle after the interrupt rises. Chip-select handling is left to the surrounding logic.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads zero, `sck` and `mosi` are low and `irq` is low.
- R2: Register offsets on `regAddr` are: mode 0 (5 bits, read back in bits 4:0, upper bits read 0), receive data 1, transmit data 2, control 3, status 4, clock divisor 6. Control, offset 5 and offset 7 read as zero.
- R3: Mode bits are: 0x01 loopback, 0x02 idle-high clock, 0x04 LSB first, 0x08 port enable, 0x10 leading-edge sampling. When not busy, `sck` sits at the idle-high bit value. With 0x10 set, data is sampled on the leading `sck` edge and changes on the trailing one; with 0x10 clear, it changes on the leading edge and is sampled on the trailing one.
- R4: One `sck` half period lasts 2×(D+1) bus clocks, where D is the divisor value 0..255. A frame has exactly 8 `sck` periods (16 edges). The interrupt becomes visible 16×2×(D+1)+1 clocks after the clock edge that accepts the start.
- R5: The transmit byte appears on `mosi` MSB first when mode bit 0x04 is 0, or LSB first when it is 1. The bits captured from `miso` are assembled in the same order into the receive register.
- R6: At the end of a frame, status bit 0x01 (receive ready) and `irq` go high while status bit 0x02 (busy) is still high. Busy falls on the next clock.
- R7: A start written while a frame is in progress is ignored. The frame keeps its timing and no second frame follows.
- R8: With port enable (0x08) clear, `sck` holds its idle level, `mosi` is low and start writes are ignored.
- R9: With loopback (0x01) set, the receive byte equals the transmitted byte regardless of `miso`.
- R10: A read of offset 1 (`regRdEn` with `regAddr`=1) returns the received byte, then clears receive ready and `irq`.
- R11: A start is a write to offset 3 with bit 0 set. A control write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects on offset 1) |
| regAddr | input | 3 | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from `regAddr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Frame-complete interrupt, level |

## Verification
The properties assume that the mode and divisor registers are not rewritten while a frame is in flight. They also assume at most one bus operation per cycle and a `miso` that changes only on the edges where the block shifts, never on the ones where it samples. The stimulus writes configuration only while the block is idle, issues a single write or read per cycle, and uses a slave model that moves `miso` on the shift edge matching the programmed phase.

// File: rtl/spi_byte_pkg.sv
`timescale 1ns/1ps
package spi_byte_pkg;

  // Field order mirrors the mode byte, bit 4 down to bit 0.
  typedef struct packed {
    logic phaseLead;   // sample on leading edge
    logic enable;
    logic lsbFirst;
    logic idleHigh;
    logic loopback;
  } modeCfg_t;

  typedef struct packed {
    logic loadFrame;   // capture transmit byte, clear counters
    logic run;         // advance the bit clock
    logic driveOut;    // let the shifter reach the pin
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_DONE,
    ST_TAIL
  } seqState_t;

  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_RX   = 3'd1;
  localparam logic [2:0] OFS_TX   = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_STAT = 3'd4;
  localparam logic [2:0] OFS_DIV  = 3'd6;

endpackage

// File: rtl/spi_byte_ctrl.sv
`timescale 1ns/1ps
module spi_byte_ctrl
  import spi_byte_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [2:0]           regAddr,
  input  logic [WORD_W-1:0]    regWrData,
  output logic [WORD_W-1:0]    regRdData,
  input  logic                 frameEnd,
  input  logic [WORD_W-1:0]    rxWord,
  output modeCfg_t             modeCfg,
  output logic [DIV_W-1:0]     divisor,
  output logic [WORD_W-1:0]    txWord,
  output dpStrobe_t            strobe,
  output logic                 busy,
  output logic                 rxReady
);

  localparam int MODE_W = $bits(modeCfg_t);

  seqState_t stateQ, stateD;
  logic [WORD_W-1:0] rxData;
  logic startReq, startOk, rxRead;

  assign startReq = regWrEn && (regAddr == OFS_CTRL) && regWrData[0];
  assign startOk  = startReq && modeCfg.enable && (stateQ == ST_IDLE);
  assign rxRead   = regRdEn && (regAddr == OFS_RX);
  assign busy     = (stateQ != ST_IDLE);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (startOk) stateD = ST_SHIFT;
      ST_SHIFT: if (frameEnd) stateD = ST_DONE;
      ST_DONE:  stateD = ST_TAIL;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      modeCfg <= '0;
      divisor <= '0;
      txWord  <= '0;
      rxData  <= '0;
      rxReady <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (regWrEn) begin
        case (regAddr)
          OFS_MODE: modeCfg <= modeCfg_t'(regWrData[MODE_W-1:0]);
          OFS_TX:   txWord  <= regWrData;
          OFS_DIV:  divisor <= regWrData[DIV_W-1:0];
          default:  ;
        endcase
      end
      if (stateQ == ST_DONE) begin
        rxData  <= rxWord;
        rxReady <= 1'b1;
      end else if (rxRead) begin
        rxReady <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_MODE: regRdData[MODE_W-1:0] = modeCfg;
      OFS_RX:   regRdData = rxData;
      OFS_TX:   regRdData = txWord;
      OFS_STAT: regRdData[1:0] = {busy, rxReady};
      OFS_DIV:  regRdData[DIV_W-1:0] = divisor;
      default:  regRdData = '0;
    endcase
  end

  assign strobe.loadFrame = startOk;
  assign strobe.run       = (stateQ == ST_SHIFT);
  assign strobe.driveOut  = busy;

endmodule

// File: rtl/spi_byte_datapath.sv
`timescale 1ns/1ps
module spi_byte_datapath
  import spi_byte_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  modeCfg_t          modeCfg,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              frameEnd,
  output logic [WORD_W-1:0] rxWord
);

  localparam int CNT_W    = DIV_W + 1;
  localparam int EDGES    = 2 * WORD_W;
  localparam int EDGE_W   = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [CNT_W-1:0]  divCnt, halfMax;
  logic [EDGE_W-1:0] edgeIdx;
  logic              sckPhase;
  logic [WORD_W-1:0] txSh, rxSh, txRev, rxRev;
  logic              tick, cphaOne, sampleNow, shiftNow, inBit;

  for (genvar i = 0; i < WORD_W; i++) begin : g_rev
    assign txRev[i] = txWord[WORD_W-1-i];
    assign rxRev[i] = rxSh[WORD_W-1-i];
  end

  assign halfMax   = {divisor, 1'b1};
  assign tick      = strobe.run && (divCnt == halfMax);
  assign cphaOne   = ~modeCfg.phaseLead;
  assign sampleNow = (edgeIdx[0] == cphaOne);
  assign shiftNow  = !sampleNow && !(cphaOne && (edgeIdx == '0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt   <= '0;
      edgeIdx  <= '0;
      sckPhase <= 1'b0;
      txSh     <= '0;
      rxSh     <= '0;
    end else if (strobe.loadFrame) begin
      divCnt   <= '0;
      edgeIdx  <= '0;
      sckPhase <= 1'b0;
      txSh     <= modeCfg.lsbFirst ? txRev : txWord;
      rxSh     <= '0;
    end else if (strobe.run) begin
      if (tick) begin
        divCnt   <= '0;
        edgeIdx  <= edgeIdx + 1'b1;
        sckPhase <= ~sckPhase;
        if (sampleNow) rxSh <= {rxSh[WORD_W-2:0], inBit};
        if (shiftNow)  txSh <= {txSh[WORD_W-2:0], 1'b0};
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign mosi     = strobe.driveOut & txSh[WORD_W-1];
  assign inBit    = modeCfg.loopback ? mosi : miso;
  assign sck      = modeCfg.idleHigh ^ sckPhase;
  assign frameEnd = tick && (edgeIdx == LAST_EDGE);
  assign rxWord   = modeCfg.lsbFirst ? rxRev : rxSh;

endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);

  modeCfg_t          modeCfg;
  dpStrobe_t         strobe;
  logic [DIV_W-1:0]  divisor;
  logic [WORD_W-1:0] txWord, rxWord;
  logic              frameEnd, busy, rxReady;

  spi_byte_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .frameEnd(frameEnd), .rxWord(rxWord),
    .modeCfg(modeCfg), .divisor(divisor), .txWord(txWord),
    .strobe(strobe), .busy(busy), .rxReady(rxReady)
  );

  spi_byte_datapath #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .modeCfg(modeCfg), .divisor(divisor),
    .txWord(txWord), .miso(miso),
    .sck(sck), .mosi(mosi), .frameEnd(frameEnd), .rxWord(rxWord)
  );

  assign irq = rxReady;

endmodule

// File: rtl/spi_byte_master_chk.sv
`timescale 1ns/1ps
module spi_byte_master_chk
  import spi_byte_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       irq,
  input logic       sck,
  input logic       mosi,
  input logic       frameEnd,
  input logic       regRdEn,
  input logic [2:0] regAddr,
  input modeCfg_t   modeCfg
);

  a_r6_busy_at_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> busy);

  a_r6_busy_drops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |=> !busy);

  a_r4_irq_follows_end: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> ##1 irq);

  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sck == modeCfg.idleHigh));

  a_r8_mosi_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mosi);

  a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!modeCfg.enable && !busy) |=> !busy);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 3'd1 && !busy) |=> !irq);

endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .irq(irq), .sck(sck), .mosi(mosi),
  .frameEnd(frameEnd), .regRdEn(regRdEn), .regAddr(regAddr), .modeCfg(modeCfg)
);

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       sck, mosi, irq;
  logic       miso = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  spi_byte_master u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // Slave model and scoreboard monitor
  bit         frameLive = 1'b0;
  int         sEdges = 0;
  bit         sCpha = 1'b0;
  logic [7:0] sWire = 8'd0;
  logic [7:0] capIn = 8'd0;
  logic [7:0] expQ[$];

  always @(sck) begin
    if (frameLive) begin
      sEdges++;
      if (sCpha ? (sEdges % 2 == 0) : (sEdges % 2 == 1))
        capIn = {capIn[6:0], mosi};
      if (sCpha && (sEdges % 2 == 1))
        miso = sWire[7 - (sEdges - 1) / 2];
      if (!sCpha && (sEdges % 2 == 0) && sEdges < 16)
        miso = sWire[7 - sEdges / 2];
      if (sEdges == 16) begin
        frameLive = 1'b0;
        if (expQ.size() == 0) begin
          check(1'b0, "R5 mosi frame without expectation", capIn, 0);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          check(capIn == e, "R5 mosi bit stream", capIn, e);
        end
      end
    end
  end

  task automatic runFrame(input logic [7:0] mode, input logic [7:0] div,
                          input logic [7:0] tx, input logic [7:0] sData,
                          input bit midStart);
    logic [7:0] d, expRx;
    int cnt, halfLen;
    halfLen = 2 * (int'(div) + 1);
    expRx   = mode[0] ? tx : sData;
    busWrite(3'd0, mode);
    busWrite(3'd6, div);
    busWrite(3'd2, tx);
    check(sck == mode[1], "R3 idle clock level", sck, mode[1]);
    sCpha  = !mode[4];
    sWire  = mode[2] ? rev8(sData) : sData;
    capIn  = 8'd0;
    sEdges = 0;
    miso   = sWire[7];
    expQ.push_back(mode[2] ? rev8(tx) : tx);
    frameLive = 1'b1;
    busWrite(3'd3, 8'h01);
    regAddr = 3'd4;
    cnt = 0;
    while (!irq && cnt < 20000) begin
      @(negedge clk);
      cnt++;
      if (midStart && cnt == 6) begin
        regWrEn = 1'b1; regAddr = 3'd3; regWrData = 8'h01;
      end else begin
        regWrEn = 1'b0; regAddr = 3'd4;
      end
    end
    check(cnt == 16 * halfLen + 1, "R4 start-to-irq clocks", cnt, 16 * halfLen + 1);
    check(regRdData == 8'h03, "R6 busy and ready at irq", regRdData, 8'h03);
    @(negedge clk);
    check(regRdData == 8'h01, "R6 busy low one clock later", regRdData, 8'h01);
    check(sEdges == 16, "R4 sck edges per frame", sEdges, 16);
    busRead(3'd1, d);
    check(d == expRx, mode[0] ? "R9 loopback receive byte" : "R5 receive byte", d, expRx);
    check(irq == 1'b0, "R10 irq cleared by read", irq, 0);
    busRead(3'd4, d);
    check(d == 8'h00, "R10 ready cleared by read", d, 0);
    if (midStart) begin
      repeat (40) @(negedge clk);
      busRead(3'd4, d);
      check(d == 8'h00, "R7 no second frame after ignored start", d, 0);
      check(sEdges == 16, "R7 no extra sck edges", sEdges, 16);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(sck == 1'b0, "R1 sck after reset", sck, 0);
    check(mosi == 1'b0, "R1 mosi after reset", mosi, 0);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    for (int a = 0; a < 8; a++) begin
      busRead(3'(a), d);
      check(d == 8'h00, "R1 register zero after reset", d, 0);
    end

    // R2 offsets and readback
    busWrite(3'd0, 8'hFF);
    busRead(3'd0, d);
    check(d == 8'h1F, "R2 mode readback width", d, 8'h1F);
    busWrite(3'd0, 8'h00);
    busWrite(3'd2, 8'hA7);
    busRead(3'd2, d);
    check(d == 8'hA7, "R2 transmit readback", d, 8'hA7);
    busWrite(3'd6, 8'h5C);
    busRead(3'd6, d);
    check(d == 8'h5C, "R2 divisor readback", d, 8'h5C);
    busRead(3'd3, d);
    check(d == 8'h00, "R2 control reads zero", d, 0);
    busWrite(3'd5, 8'hEE);
    busRead(3'd5, d);
    check(d == 8'h00, "R2 offset 5 reads zero", d, 0);

    // R8 disabled port
    busWrite(3'd0, 8'h02);
    check(sck == 1'b1, "R8 disabled sck idle high", sck, 1);
    busWrite(3'd3, 8'h01);
    repeat (10) @(negedge clk);
    busRead(3'd4, d);
    check(d == 8'h00, "R8 start ignored when disabled", d, 0);
    check(mosi == 1'b0, "R8 mosi low when disabled", mosi, 0);
    check(sck == 1'b1, "R8 sck held while disabled", sck, 1);

    // R11 control write without start bit
    busWrite(3'd0, 8'h08);
    busWrite(3'd3, 8'h02);
    repeat (4) @(negedge clk);
    busRead(3'd4, d);
    check(d == 8'h00, "R11 control without bit0 ignored", d, 0);

    // R3 R4 R5 R6 R10: each clock mode, both bit orders
    runFrame(8'h18, 8'd0, 8'hA5, 8'h3C, 1'b0);
    runFrame(8'h08, 8'd1, 8'h96, 8'h5A, 1'b0);
    runFrame(8'h1A, 8'd2, 8'h0F, 8'hF1, 1'b0);
    runFrame(8'h0A, 8'd0, 8'h81, 8'h7E, 1'b0);
    runFrame(8'h1C, 8'd0, 8'h01, 8'h80, 1'b0);
    runFrame(8'h0E, 8'd1, 8'h6C, 8'h35, 1'b0);
    // R9 loopback
    runFrame(8'h19, 8'd0, 8'hC3, 8'h00, 1'b0);
    runFrame(8'h0B, 8'd0, 8'h5D, 8'hFF, 1'b0);
    // R7 start while busy
    runFrame(8'h18, 8'd0, 8'h3A, 8'hC5, 1'b1);
    // R4 largest divisor
    runFrame(8'h18, 8'd255, 8'hE7, 8'h18, 1'b0);

    check(expQ.size() == 0, "R5 all frames observed", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule